// File: doc/BRIEF.md
# Candidate Scheduler for Parallel Search Cores

This block controls an exhaustive search over fixed-length text candidates. A work block arrives as a start candidate and a count n. An internal generator then produces consecutive candidates, one per cycle while the consumer accepts them. Each candidate carries its running index. The stream is dealt out to an array of search cores. Each core holds `SLOTS` candidates at a time. Each core later reports that it has finished its batch, or reports a hit on one of its slots.

Filling happens in rounds. Core 0 receives slots 0 to SLOTS-1, then core 1 receives its slots, and so on. After the last slot of the last core, the stream stops. It stays stopped until every core has reported completion since that round began, and the next round starts after that. When n is not a multiple of NUM_CORES×SLOTS, the final round still deals every slot, but the slots beyond the n-th candidate are flagged as not live. A hit from any core ends the block at once: the scheduler records the index of the winning candidate, raises `found` and goes idle. The block also ends, without a hit, when all n candidates have been dealt and every core has drained.

Both data paths use valid/ready:
- Work-block input: `blk_ready` is high only while idle. A work block is taken on a cycle where `blk_valid` and `blk_ready` are both high.
- Candidate output: `cand_valid` stays high through a fill round. A beat transfers on a cycle where `cand_valid` and `cand_ready` are both high. With `cand_ready` low, every candidate field holds.

Core completion, hit reports and status are plain single-cycle or level signals.

Top module: `cand_sched`

## Requirements
- R1: After reset, `idle`=1, `blk_ready`=1, `found`=0, `cand_valid`=0 and `gen_done`=1.
- R2: A work block is accepted only when `blk_valid` and `blk_ready` are high together, and `blk_ready` is high exactly while the block is idle. `blk_valid` pulses while busy do not change the candidate stream.
- R3: Candidates are strings of CHARS bytes, with the last character in bits [7:0]. Each byte lies in FIRST_CHAR to FIRST_CHAR+RADIX-1. The first live candidate equals the start candidate and has index 0. Each later live candidate is the previous one plus one in base RADIX. Increments carry from the last character toward the first, and a character at the top value wraps to FIRST_CHAR. The index rises by one per live beat.
- R4: While `cand_valid`=1 and `cand_ready`=0, `cand_data`, `cand_index`, `cand_core` and `cand_slot` hold their values. No candidate is lost or repeated.
- R5: Within a round, beats go to core 0 slots 0..SLOTS-1, then core 1 slots 0..SLOTS-1, and so on up to core NUM_CORES-1. `cand_core` and `cand_slot` name the target of each beat.
- R6: After the last slot of the last core transfers, `cand_valid` stays 0 until every core has pulsed `core_done` at least once since that round began. The next round then starts in the cycle after the last missing pulse.
- R7: `cand_live`=1 for the first n beats of a block and 0 for the padding beats that fill the rest of the final round.
- R8: `gen_done` falls when a block with n>0 is accepted. It rises once the n-th live beat has transferred.
- R9: When all cores have drained and `gen_done`=1, the block returns to idle in the next cycle with `found`=0.
- R10: A `core_match` pulse while busy returns the block to idle in the next cycle with `found`=1. `found_index` is then the index of the first candidate dealt to that core in the current round plus its reported slot. When several cores report a hit in the same cycle, the lowest-numbered core wins.
- R11: `core_match` pulses while idle are ignored: `found` and `found_index` hold.
- R12: A work block with n=0 is accepted, clears `found`, deals no beat and leaves the block idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| blk_valid | input | 1 | Work block offered |
| blk_ready | output | 1 | Work block can be taken (idle) |
| blk_start | input | CHARS*CHAR_W | Start candidate |
| blk_count | input | CNT_W | Number of candidates n |
| cand_valid | output | 1 | Candidate beat offered |
| cand_ready | input | 1 | Consumer takes the beat |
| cand_data | output | CHARS*CHAR_W | Candidate text |
| cand_index | output | CNT_W | Running index of the candidate |
| cand_live | output | 1 | Beat is a real candidate, not padding |
| cand_core | output | CORE_W | Target core of the beat |
| cand_slot | output | SLOT_W | Target slot within that core |
| core_done | input | NUM_CORES | Per-core batch complete pulse |
| core_match | input | NUM_CORES | Per-core hit pulse |
| core_hit_slot | input | NUM_CORES*SLOT_W | Slot of the hit, per core |
| idle | output | 1 | No block in progress |
| found | output | 1 | Last block ended on a hit |
| found_index | output | CNT_W | Index of the winning candidate |
| gen_done | output | 1 | All n candidates of the block dealt |

## Verification
The hardest situation to reach is a hit in a later round. There, `found_index` depends on the per-core base recorded while dealing that round. Tests with a hit also include one where two cores report in the same cycle. To get there, the stimulus lets the first round drain completely, under random back-pressure, and then injects hits on a chosen slot of core 0 and core 1 together. The partial final round and the character carry chain are reached with a small radix and a start candidate close to wrap-around. The wait-for-drain rule is exercised by releasing one core's completion several cycles before the others.

// File: rtl/cand_sched_pkg.sv
package cand_sched_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_WAIT = 2'd2
  } sched_state_e;
endpackage

// File: rtl/cand_sched_gen.sv
// Candidate counter: mixed-radix increment of a byte string plus index.
module cand_sched_gen #(
  parameter int CHARS      = 8,
  parameter int CHAR_W     = 8,
  parameter int FIRST_CHAR = 97,
  parameter int RADIX      = 26,
  parameter int CNT_W      = 32,
  localparam int CAND_W    = CHARS * CHAR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CAND_W-1:0] start,
  input  logic [CNT_W-1:0]  total,
  input  logic              step,
  output logic [CAND_W-1:0] cand,
  output logic [CNT_W-1:0]  index,
  output logic              done
);
  localparam logic [CHAR_W-1:0] LO = CHAR_W'(FIRST_CHAR);
  localparam logic [CHAR_W-1:0] HI = CHAR_W'(FIRST_CHAR + RADIX - 1);

  logic [CAND_W-1:0] cand_q, cand_nx;
  logic [CNT_W-1:0]  index_q, total_q;
  logic [CHARS-1:0]  carry;

  assign carry[0] = 1'b1;

  for (genvar g = 0; g < CHARS; g++) begin : g_digit
    logic [CHAR_W-1:0] ch;
    logic              at_top;
    assign ch     = cand_q[g*CHAR_W +: CHAR_W];
    assign at_top = (ch == HI);
    assign cand_nx[g*CHAR_W +: CHAR_W] = !carry[g] ? ch : (at_top ? LO : ch + 1'b1);
    if (g < CHARS - 1) begin : g_carry
      assign carry[g+1] = carry[g] & at_top;
    end
  end

  assign done  = (index_q == total_q);
  assign cand  = cand_q;
  assign index = index_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_q  <= {CHARS{LO}};
      index_q <= '0;
      total_q <= '0;
    end else if (load) begin
      cand_q  <= start;
      index_q <= '0;
      total_q <= total;
    end else if (step && !done) begin
      cand_q  <= cand_nx;
      index_q <= index_q + 1'b1;
    end
  end
endmodule

// File: rtl/cand_sched_slots.sv
// Slot and core pointers for one fill round, plus per-core base index.
module cand_sched_slots #(
  parameter int NUM_CORES = 2,
  parameter int SLOTS     = 83,
  parameter int CNT_W     = 32,
  localparam int SLOT_W   = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              advance,
  input  logic [CNT_W-1:0]  cur_index,
  input  logic [CORE_W-1:0] hit_core,
  input  logic [SLOT_W-1:0] hit_slot,
  output logic [CORE_W-1:0] core_ptr,
  output logic [SLOT_W-1:0] slot_ptr,
  output logic              round_end,
  output logic [CNT_W-1:0]  hit_index
);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOTS - 1);
  localparam logic [CORE_W-1:0] CORE_LAST = CORE_W'(NUM_CORES - 1);

  logic [CORE_W-1:0] core_q;
  logic [SLOT_W-1:0] slot_q;
  logic              slot_wrap;
  logic [CNT_W-1:0]  base_q [NUM_CORES];
  logic [CNT_W-1:0]  base_sel;

  assign slot_wrap = (slot_q == SLOT_LAST);
  assign round_end = slot_wrap && (core_q == CORE_LAST);
  assign core_ptr  = core_q;
  assign slot_ptr  = slot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_q <= '0;
      slot_q <= '0;
    end else if (clear) begin
      core_q <= '0;
      slot_q <= '0;
    end else if (advance) begin
      if (slot_wrap) begin
        slot_q <= '0;
        core_q <= (core_q == CORE_LAST) ? '0 : core_q + 1'b1;
      end else begin
        slot_q <= slot_q + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_base
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        base_q[g] <= '0;
      else if (advance && (slot_q == '0) && (core_q == CORE_W'(g)))
        base_q[g] <= cur_index;
    end
  end

  always_comb begin
    base_sel = '0;
    for (int i = 0; i < NUM_CORES; i++)
      if (hit_core == CORE_W'(i)) base_sel = base_q[i];
  end

  assign hit_index = base_sel + CNT_W'(hit_slot);
endmodule

// File: rtl/cand_sched_drain.sv
// Collects per-core completion and picks the winning hit.
module cand_sched_drain #(
  parameter int NUM_CORES = 2,
  parameter int SLOT_W    = 7,
  parameter int CORE_W    = 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clear,
  input  logic [NUM_CORES-1:0]        core_done,
  input  logic [NUM_CORES-1:0]        core_match,
  input  logic [NUM_CORES*SLOT_W-1:0] core_hit_slot,
  output logic                        all_drained,
  output logic                        any_match,
  output logic [CORE_W-1:0]           hit_core,
  output logic [SLOT_W-1:0]           hit_slot
);
  logic [NUM_CORES-1:0] mask_q;

  assign all_drained = &(mask_q | core_done);
  assign any_match   = |core_match;

  always_comb begin
    hit_core = '0;
    hit_slot = '0;
    for (int i = NUM_CORES - 1; i >= 0; i--) begin
      if (core_match[i]) begin
        hit_core = CORE_W'(i);
        hit_slot = core_hit_slot[i*SLOT_W +: SLOT_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mask_q <= '0;
    else if (clear)  mask_q <= '0;
    else             mask_q <= mask_q | core_done;
  end
endmodule

// File: rtl/cand_sched.sv
// Round-based candidate scheduler feeding an array of search cores.
module cand_sched
  import cand_sched_pkg::*;
#(
  parameter int NUM_CORES  = 2,
  parameter int SLOTS      = 83,
  parameter int CHARS      = 8,
  parameter int CHAR_W     = 8,
  parameter int FIRST_CHAR = 97,
  parameter int RADIX      = 26,
  parameter int CNT_W      = 32,
  localparam int CAND_W    = CHARS * CHAR_W,
  localparam int SLOT_W    = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int CORE_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        blk_valid,
  output logic                        blk_ready,
  input  logic [CAND_W-1:0]           blk_start,
  input  logic [CNT_W-1:0]            blk_count,
  output logic                        cand_valid,
  input  logic                        cand_ready,
  output logic [CAND_W-1:0]           cand_data,
  output logic [CNT_W-1:0]            cand_index,
  output logic                        cand_live,
  output logic [CORE_W-1:0]           cand_core,
  output logic [SLOT_W-1:0]           cand_slot,
  input  logic [NUM_CORES-1:0]        core_done,
  input  logic [NUM_CORES-1:0]        core_match,
  input  logic [NUM_CORES*SLOT_W-1:0] core_hit_slot,
  output logic                        idle,
  output logic                        found,
  output logic [CNT_W-1:0]            found_index,
  output logic                        gen_done
);
  sched_state_e      state_q, state_d;
  logic              accept, fire, step, start_round;
  logic              round_end, all_drained, any_match, gen_done_w;
  logic [CORE_W-1:0] hit_core;
  logic [SLOT_W-1:0] hit_slot;
  logic [CNT_W-1:0]  hit_index;
  logic              found_q;
  logic [CNT_W-1:0]  found_index_q;

  assign idle       = (state_q == ST_IDLE);
  assign blk_ready  = idle;
  assign accept     = blk_valid && blk_ready;
  assign cand_valid = (state_q == ST_FILL);
  assign fire       = cand_valid && cand_ready;
  assign cand_live  = !gen_done_w;
  assign step       = fire && cand_live;
  assign gen_done   = gen_done_w;

  cand_sched_gen #(
    .CHARS(CHARS), .CHAR_W(CHAR_W), .FIRST_CHAR(FIRST_CHAR),
    .RADIX(RADIX), .CNT_W(CNT_W)
  ) u_gen (
    .clk(clk), .rst_n(rst_n), .load(accept), .start(blk_start),
    .total(blk_count), .step(step), .cand(cand_data),
    .index(cand_index), .done(gen_done_w)
  );

  cand_sched_slots #(
    .NUM_CORES(NUM_CORES), .SLOTS(SLOTS), .CNT_W(CNT_W)
  ) u_slots (
    .clk(clk), .rst_n(rst_n), .clear(accept), .advance(fire),
    .cur_index(cand_index), .hit_core(hit_core), .hit_slot(hit_slot),
    .core_ptr(cand_core), .slot_ptr(cand_slot), .round_end(round_end),
    .hit_index(hit_index)
  );

  cand_sched_drain #(
    .NUM_CORES(NUM_CORES), .SLOT_W(SLOT_W), .CORE_W(CORE_W)
  ) u_drain (
    .clk(clk), .rst_n(rst_n), .clear(start_round), .core_done(core_done),
    .core_match(core_match), .core_hit_slot(core_hit_slot),
    .all_drained(all_drained), .any_match(any_match),
    .hit_core(hit_core), .hit_slot(hit_slot)
  );

  always_comb begin
    state_d     = state_q;
    start_round = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (accept && (blk_count != '0)) begin
          state_d     = ST_FILL;
          start_round = 1'b1;
        end
      end
      ST_FILL: begin
        if (any_match)              state_d = ST_IDLE;
        else if (fire && round_end) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (any_match) begin
          state_d = ST_IDLE;
        end else if (all_drained) begin
          if (gen_done_w) begin
            state_d = ST_IDLE;
          end else begin
            state_d     = ST_FILL;
            start_round = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q       <= ST_IDLE;
      found_q       <= 1'b0;
      found_index_q <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        found_q <= 1'b0;
      end else if (!idle && any_match) begin
        found_q       <= 1'b1;
        found_index_q <= hit_index;
      end
    end
  end

  assign found       = found_q;
  assign found_index = found_index_q;
endmodule

// File: rtl/cand_sched_chk.sv
// Protocol checker for cand_sched, attached by bind.
module cand_sched_chk #(
  parameter int NUM_CORES = 2,
  parameter int SLOTS     = 83,
  parameter int CNT_W     = 32,
  parameter int CAND_W    = 64,
  parameter int SLOT_W    = 7,
  parameter int CORE_W    = 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 blk_valid,
  input logic [CNT_W-1:0]     blk_count,
  input logic                 idle,
  input logic                 cand_valid,
  input logic                 cand_ready,
  input logic [CAND_W-1:0]    cand_data,
  input logic [CNT_W-1:0]     cand_index,
  input logic                 cand_live,
  input logic [CORE_W-1:0]    cand_core,
  input logic [SLOT_W-1:0]    cand_slot,
  input logic [NUM_CORES-1:0] core_match,
  input logic                 found,
  input logic [CNT_W-1:0]     found_index,
  input logic                 gen_done
);
  // R2 / R8: a non-empty block leaves idle and clears the done flag
  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    idle && blk_valid && (blk_count != '0) |=> !idle && !gen_done);

  // R4: a stalled beat holds all its fields
  p_stall_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cand_valid && !cand_ready && !(|core_match) |=>
      cand_valid && $stable(cand_data) && $stable(cand_index) &&
      $stable(cand_core) && $stable(cand_slot));

  // R3: a taken live beat is followed by the next index
  p_index_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cand_valid && cand_ready && cand_live && !(|core_match) |=>
      !cand_valid || (cand_index == $past(cand_index) + CNT_W'(1)));

  // R5: slots advance in order inside one core
  p_slot_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cand_valid && cand_ready && (cand_slot != SLOT_W'(SLOTS - 1)) && !(|core_match) |=>
      cand_valid && (cand_slot == $past(cand_slot) + SLOT_W'(1)) && $stable(cand_core));

  // R10: a hit while busy ends the block with found set
  p_match_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !idle && (|core_match) |=> idle && found);

  // R11: idle state keeps the result regardless of hit pulses
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    idle && !blk_valid |=> $stable(found) && $stable(found_index));

  // R9: no beat is offered while idle
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !cand_valid);
endmodule

bind cand_sched cand_sched_chk #(
  .NUM_CORES(NUM_CORES), .SLOTS(SLOTS), .CNT_W(CNT_W),
  .CAND_W(CAND_W), .SLOT_W(SLOT_W), .CORE_W(CORE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .blk_valid(blk_valid), .blk_count(blk_count),
  .idle(idle), .cand_valid(cand_valid), .cand_ready(cand_ready),
  .cand_data(cand_data), .cand_index(cand_index), .cand_live(cand_live),
  .cand_core(cand_core), .cand_slot(cand_slot), .core_match(core_match),
  .found(found), .found_index(found_index), .gen_done(gen_done)
);

// File: tb/cand_sched_test.sv
`timescale 1ns/1ps
module cand_sched_test;
  localparam int NC   = 2;
  localparam int NS   = 83;
  localparam int NCH  = 3;
  localparam int CHW  = 8;
  localparam int FC   = 48;
  localparam int RDX  = 5;
  localparam int CNTW = 32;
  localparam int CW   = NCH * CHW;
  localparam int SW   = 7;
  localparam int KW   = 1;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            blk_valid = 1'b0;
  logic            blk_ready;
  logic [CW-1:0]   blk_start = '0;
  logic [CNTW-1:0] blk_count = '0;
  logic            cand_valid;
  logic            cand_ready = 1'b0;
  logic [CW-1:0]   cand_data;
  logic [CNTW-1:0] cand_index;
  logic            cand_live;
  logic [KW-1:0]   cand_core;
  logic [SW-1:0]   cand_slot;
  logic [NC-1:0]   core_done = '0;
  logic [NC-1:0]   core_match = '0;
  logic [NC*SW-1:0] core_hit_slot = '0;
  logic            idle, found, gen_done;
  logic [CNTW-1:0] found_index;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  cand_sched #(
    .NUM_CORES(NC), .SLOTS(NS), .CHARS(NCH), .CHAR_W(CHW),
    .FIRST_CHAR(FC), .RADIX(RDX), .CNT_W(CNTW)
  ) uut (
    .clk(clk), .rst_n(rst_n), .blk_valid(blk_valid), .blk_ready(blk_ready),
    .blk_start(blk_start), .blk_count(blk_count), .cand_valid(cand_valid),
    .cand_ready(cand_ready), .cand_data(cand_data), .cand_index(cand_index),
    .cand_live(cand_live), .cand_core(cand_core), .cand_slot(cand_slot),
    .core_done(core_done), .core_match(core_match), .core_hit_slot(core_hit_slot),
    .idle(idle), .found(found), .found_index(found_index), .gen_done(gen_done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // start + k in base RDX, last character least significant
  function automatic logic [CW-1:0] exp_cand(input logic [CW-1:0] s, input int k);
    logic [CW-1:0] r;
    int carry;
    int t;
    r = s;
    carry = k;
    for (int i = 0; i < NCH; i++) begin
      t = int'(r[i*CHW +: CHW]) - FC + carry;
      r[i*CHW +: CHW] = CHW'(FC + (t % RDX));
      carry = t / RDX;
    end
    return r;
  endfunction

  function automatic logic [CW-1:0] rand_cand();
    logic [CW-1:0] r;
    for (int i = 0; i < NCH; i++) r[i*CHW +: CHW] = CHW'(FC + ($urandom % RDX));
    return r;
  endfunction

  task automatic run_block(input logic [CW-1:0] s, input int n, input int rdy_pct,
                           input int hit_k, input bit dual);
    int e, beat, rs, p;
    bit stalled;
    logic [CW-1:0]   hold_d;
    logic [CNTW-1:0] hold_i;
    e = 0; beat = 0; rs = 0; stalled = 0;
    hold_d = '0; hold_i = '0;
    @(negedge clk);
    chk(blk_ready == 1'b1, "R2", "ready while idle", blk_ready, 1);
    blk_valid = 1'b1; blk_start = s; blk_count = CNTW'(n);
    @(negedge clk);
    blk_valid = 1'b0;
    if (n == 0) begin
      chk(idle && !cand_valid, "R12", "empty block stays idle", {idle, cand_valid}, 2'b10);
      chk(!found, "R12", "found cleared", found, 0);
      chk(gen_done, "R8", "done for empty block", gen_done, 1);
      return;
    end
    forever begin
      while (beat < NC * NS) begin
        chk(cand_valid && !idle, "R6", "stream during fill", cand_valid, 1);
        if (stalled)
          chk(cand_data == hold_d && cand_index == hold_i, "R4", "frozen under stall",
              cand_index, hold_i);
        chk(!blk_ready, "R2", "not ready while busy", blk_ready, 0);
        cand_ready = (($urandom % 100) < rdy_pct);
        blk_valid  = (($urandom % 8) == 0);
        blk_start  = rand_cand();
        blk_count  = $urandom;
        if (cand_ready) begin
          chk(cand_core == KW'(beat / NS) && cand_slot == SW'(beat % NS), "R5",
              "core/slot order", {cand_core, cand_slot}, {KW'(beat / NS), SW'(beat % NS)});
          chk(cand_live == (e < n), "R7", "live flag", cand_live, (e < n));
          if (e < n) begin
            chk(cand_data == exp_cand(s, e), "R3", "candidate text", cand_data, exp_cand(s, e));
            chk(cand_index == CNTW'(e), "R3", "candidate index", cand_index, e);
            e++;
          end
          beat++;
          stalled = 0;
        end else begin
          stalled = 1;
          hold_d = cand_data;
          hold_i = cand_index;
        end
        @(negedge clk);
      end
      cand_ready = 1'b0; blk_valid = 1'b0; beat = 0; stalled = 0;
      chk(gen_done == (e == n), "R8", "done after round", gen_done, (e == n));
      chk(!cand_valid, "R6", "paused after last slot", cand_valid, 0);
      if (hit_k >= rs && hit_k < e) begin
        p = hit_k - rs;
        core_match = '0;
        core_hit_slot = '0;
        core_match[p / NS] = 1'b1;
        core_hit_slot[(p / NS) * SW +: SW] = SW'(p % NS);
        if (dual) begin
          core_match[NC-1] = 1'b1;
          core_hit_slot[(NC-1) * SW +: SW] = SW'(5);
        end
        @(negedge clk);
        core_match = '0;
        chk(idle && found, "R10", "hit ends block", {idle, found}, 2'b11);
        chk(found_index == CNTW'(hit_k), "R10", "winning index", found_index, hit_k);
        return;
      end
      repeat (3) begin
        @(negedge clk);
        chk(!cand_valid, "R6", "waiting for drain", cand_valid, 0);
      end
      core_done[0] = 1'b1;
      @(negedge clk);
      core_done = '0;
      repeat (2) @(negedge clk);
      chk(!cand_valid && !idle, "R6", "one core drained is not enough",
          {cand_valid, idle}, 0);
      for (int c = 1; c < NC; c++) core_done[c] = 1'b1;
      @(negedge clk);
      core_done = '0;
      if (e == n) begin
        chk(idle && !found, "R9", "clean finish", {idle, found}, 2'b10);
        return;
      end
      chk(cand_valid, "R6", "refill after drain", cand_valid, 1);
      rs = e;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [CNTW-1:0] keep_idx;
    void'($urandom(32'd7531));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(idle && blk_ready && !found && !cand_valid && gen_done, "R1", "reset state",
        {idle, blk_ready, found, cand_valid, gen_done}, 5'b11001);

    run_block({8'h30, 8'h30, 8'h30}, NC * NS, 100, -1, 0);
    run_block({8'h34, 8'h34, 8'h33}, 200, 60, -1, 0);
    run_block(rand_cand(), 1, 30, -1, 0);
    for (int i = 0; i < 3; i++) run_block(rand_cand(), 1 + ($urandom % 400), 50 + i * 20, -1, 0);

    run_block(rand_cand(), 300, 70, 100, 0);
    run_block(rand_cand(), 300, 70, NC * NS + 14, 1);

    keep_idx = found_index;
    @(negedge clk);
    core_match = 2'b01;
    core_hit_slot = '0;
    core_hit_slot[SW-1:0] = SW'(3);
    @(negedge clk);
    core_match = '0;
    @(negedge clk);
    chk(found && found_index == keep_idx, "R11", "idle hit ignored", found_index, keep_idx);

    run_block(rand_cand(), 0, 100, -1, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule